// File: doc/BRIEF.md
# Two-Stage Half-Bridge Overcurrent Supervisor

This block watches a pair of overcurrent comparator flags on a half-bridge power stage and answers a trip in two stages. A trip first causes a one-cycle request to switch off the gate that is conducting. One cycle later the block requests that the opposite gate turn on, so the tank current reverses instead of growing. Each further trip is answered the same way.

If trips keep arriving for longer than a persistence window, the block escalates. It raises a shutdown output that holds both gates off for a fixed interval. When that interval ends it drops the shutdown and emits a one-cycle soft-start request. Both intervals are counted in ticks of an external timebase, such as a 1 ms strobe, with lengths `PERSIST_TICKS` and `SHUT_TICKS`.

The persistence count is cleared when a whole switching period passes with no trip. A switching period is the interval between two rising edges of the high-side gate state.

Top module: `ocpProtect`

## Requirements
- R1: A trip is a 0-to-1 transition of either `ocpPos` or `ocpNeg`, sampled at a clock edge, outside shutdown. A flag that stays high produces no further trip.
- R2: On the clock edge after a trip, `offReq` pulses for exactly one cycle on the side that is conducting. Bit 1 is the high side and is used when `gateHi`=1. Bit 0 is the low side and is used when `gateHi`=0.
- R3: One cycle after an off request, `xferReq` pulses for one cycle on the opposite side. An off request on bit 1 gives a transfer on bit 0, and the reverse.
- R4: The first trip starts a tick count, and a tick sampled in the same cycle as that trip is not counted. Later trips do not restart the count. `shutdown` rises on the edge that samples the (`PERSIST_TICKS`+1)-th counted tick, provided the count has not been cleared.
- R5: A rising edge of `gateHi` ends a switching period. If a full period passed with no trip, that edge clears the tick count and the block returns to idle. A trip in every period keeps the count running.
- R6: `shutdown` stays high until the edge that samples the `SHUT_TICKS`-th tick after shutdown was entered. It falls on that edge.
- R7: `softStart` is high for exactly the one cycle that follows the fall of `shutdown`, and never at any other time.
- R8: During shutdown, flag transitions give no `offReq` and no `xferReq`, and they do not change the shutdown length. A flag held high across the end of shutdown causes no trip.
- R9: While reset is held and right after it, all outputs are low.
- R10: A transfer request that would fall in the cycle where shutdown is entered is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ocpPos | input | 1 | Current above high reference flag |
| ocpNeg | input | 1 | Current below low reference flag |
| gateHi | input | 1 | 1 while high-side gate conducts, 0 while low side |
| tick | input | 1 | One-cycle timebase strobe |
| offReq | output | 2 | Gate-off request, bit 1 high side, bit 0 low side |
| xferReq | output | 2 | Opposite-gate turn-on request, same bit order |
| shutdown | output | 1 | Both gates held off |
| softStart | output | 1 | One-cycle restart request |

## Verification
A wrong state in this block shows up at the ports with a known delay. A missed transition or a lost persistence count appears as a shutdown that comes one or more ticks too early or too late. A stale period flag appears as a count that survives a clean period, so shutdown comes early on a later fault. A stuck sequencer state appears within one cycle, as off or transfer requests during shutdown or as a misplaced soft-start pulse. The bench therefore sweeps every tick position in both windows, and every gate state against every flag.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FAULT = 2'd1,
    ST_SHUT  = 2'd2
  } ocpState_t;

  // Strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic persistClr;
    logic persistInc;
    logic shutClr;
    logic shutInc;
  } dpStrobe_t;

endpackage

// File: rtl/ocpCounters.sv
module ocpCounters
  import ocp_pkg::*;
#(
  parameter int PERSIST_TICKS = 10,
  parameter int SHUT_TICKS    = 550
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      persistAtLimit,
  output logic      shutAtLast
);

  localparam int PW = $clog2(PERSIST_TICKS + 1);
  localparam int SW = $clog2(SHUT_TICKS + 1);
  localparam logic [PW-1:0] PERSIST_LIMIT = PW'(PERSIST_TICKS);
  localparam logic [SW-1:0] SHUT_LAST     = SW'(SHUT_TICKS - 1);

  logic [PW-1:0] persistCnt;
  logic [SW-1:0] shutCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      persistCnt <= '0;
    end else if (strobe.persistClr) begin
      persistCnt <= '0;
    end else if (strobe.persistInc) begin
      persistCnt <= persistCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shutCnt <= '0;
    end else if (strobe.shutClr) begin
      shutCnt <= '0;
    end else if (strobe.shutInc) begin
      shutCnt <= shutCnt + 1'b1;
    end
  end

  assign persistAtLimit = (persistCnt == PERSIST_LIMIT);
  assign shutAtLast     = (shutCnt == SHUT_LAST);

  // R4: persistence count never runs past its window
  assert_persist_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    persistCnt <= PERSIST_LIMIT);

  // R6: shutdown count never runs past its interval
  assert_shut_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    shutCnt <= SHUT_LAST);

endmodule

// File: rtl/ocpSequencer.sv
module ocpSequencer
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ocpPos,
  input  logic       ocpNeg,
  input  logic       gateHi,
  input  logic       tick,
  input  logic       persistAtLimit,
  input  logic       shutAtLast,
  output dpStrobe_t  strobe,
  output logic [1:0] offReq,
  output logic [1:0] xferReq,
  output logic       shutdown,
  output logic       softStart
);

  localparam int SIDES = 2;

  ocpState_t state, stateNext;
  logic [SIDES-1:0] flagIn, flagQ, flagRise;
  logic gateHiQ, periodSeen;
  logic trig, periodEnd, goShut, exitShut, quietPeriod;

  assign flagIn = {ocpPos, ocpNeg};

  for (genvar s = 0; s < SIDES; s++) begin : g_rise
    assign flagRise[s] = flagIn[s] & ~flagQ[s];
  end

  always_comb begin
    trig        = (state != ST_SHUT) && (|flagRise);
    periodEnd   = gateHi && !gateHiQ;
    quietPeriod = periodEnd && !periodSeen && !trig;
    goShut      = 1'b0;
    exitShut    = 1'b0;
    stateNext   = state;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        if (trig) begin
          stateNext         = ST_FAULT;
          strobe.persistClr = 1'b1;
        end
      end
      ST_FAULT: begin
        if (tick && persistAtLimit) begin
          goShut            = 1'b1;
          stateNext         = ST_SHUT;
          strobe.persistClr = 1'b1;
          strobe.shutClr    = 1'b1;
        end else if (quietPeriod) begin
          stateNext         = ST_IDLE;
          strobe.persistClr = 1'b1;
        end else begin
          strobe.persistInc = tick;
        end
      end
      ST_SHUT: begin
        if (tick && shutAtLast) begin
          exitShut  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.shutInc = tick;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      flagQ      <= '0;
      gateHiQ    <= 1'b0;
      periodSeen <= 1'b0;
      offReq     <= '0;
      xferReq    <= '0;
      softStart  <= 1'b0;
    end else begin
      state     <= stateNext;
      flagQ     <= flagIn;
      gateHiQ   <= gateHi;
      softStart <= exitShut;
      if (exitShut || goShut) begin
        periodSeen <= 1'b0;
      end else if (periodEnd) begin
        periodSeen <= trig;
      end else if (trig) begin
        periodSeen <= 1'b1;
      end
      offReq  <= (trig && !goShut) ? (gateHi ? 2'b10 : 2'b01) : 2'b00;
      xferReq <= (goShut || state == ST_SHUT) ? 2'b00 : {offReq[0], offReq[1]};
    end
  end

  assign shutdown = (state == ST_SHUT);

  // R2: never both sides switched off by one request
  assert_off_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(offReq));

  // R3: a transfer targets the side opposite to the previous off request
  assert_xfer_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    xferReq[1] |-> $past(offReq[0]));
  assert_xfer_lo_R3: assert property (@(posedge clk) disable iff (!rstN)
    xferReq[0] |-> $past(offReq[1]));

  // R8: no gate requests while shut down
  assert_quiet_shut_R8: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |-> (offReq == 2'b00) && (xferReq == 2'b00));

  // R4: shutdown only begins on a timebase tick
  assert_shut_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdown) |-> $past(tick));

  // R7: soft start is a single pulse right after shutdown ends
  assert_soft_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    softStart |=> !softStart);
  assert_soft_after_shut_R7: assert property (@(posedge clk) disable iff (!rstN)
    softStart |-> $past(shutdown) && !shutdown);

endmodule

// File: rtl/ocpProtect.sv
module ocpProtect
  import ocp_pkg::*;
#(
  parameter int PERSIST_TICKS = 10,
  parameter int SHUT_TICKS    = 550
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ocpPos,
  input  logic       ocpNeg,
  input  logic       gateHi,
  input  logic       tick,
  output logic [1:0] offReq,
  output logic [1:0] xferReq,
  output logic       shutdown,
  output logic       softStart
);

  dpStrobe_t strobe;
  logic persistAtLimit, shutAtLast;

  ocpSequencer i_seq (
    .clk            (clk),
    .rstN           (rstN),
    .ocpPos         (ocpPos),
    .ocpNeg         (ocpNeg),
    .gateHi         (gateHi),
    .tick           (tick),
    .persistAtLimit (persistAtLimit),
    .shutAtLast     (shutAtLast),
    .strobe         (strobe),
    .offReq         (offReq),
    .xferReq        (xferReq),
    .shutdown       (shutdown),
    .softStart      (softStart)
  );

  ocpCounters #(
    .PERSIST_TICKS (PERSIST_TICKS),
    .SHUT_TICKS    (SHUT_TICKS)
  ) i_cnt (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .persistAtLimit (persistAtLimit),
    .shutAtLast     (shutAtLast)
  );

endmodule

// File: tb/test_ocpProtect.sv
`timescale 1ns/1ps
module test_ocpProtect;

  localparam int P = 3;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ocpPos = 1'b0, ocpNeg = 1'b0, gateHi = 1'b0, tick = 1'b0;
  logic [1:0] offReq, xferReq;
  logic shutdown, softStart;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ocpProtect #(.PERSIST_TICKS(P), .SHUT_TICKS(S)) i_ocpProtect (
    .clk(clk), .rstN(rstN), .ocpPos(ocpPos), .ocpNeg(ocpNeg),
    .gateHi(gateHi), .tick(tick), .offReq(offReq), .xferReq(xferReq),
    .shutdown(shutdown), .softStart(softStart)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; outputs observed at the following falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  task automatic tripLow();
    ocpPos = 1'b1;
    cyc();
    ocpPos = 1'b0;
    cyc();
    cyc();
  endtask

  // two gateHi rising edges with no trip
  task automatic cleanPeriods();
    for (int k = 0; k < 2; k++) begin
      gateHi = 1'b1; cyc();
      gateHi = 1'b0; cyc();
    end
  endtask

  task automatic finishShutdown();
    for (int m = 0; m < S; m++) tickOnce();
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    // R9: reset state
    check("R9 offReq", int'(offReq), 0);
    check("R9 xferReq", int'(xferReq), 0);
    check("R9 shutdown", int'(shutdown), 0);
    check("R9 softStart", int'(softStart), 0);
    rstN = 1'b1;
    cyc();
    check("R9 shutdown after release", int'(shutdown), 0);

    // R1 R2 R3: every gate state against every flag
    for (int g = 0; g < 2; g++) begin
      for (int f = 0; f < 2; f++) begin
        gateHi = g[0];
        cyc();
        if (f == 0) ocpPos = 1'b1; else ocpNeg = 1'b1;
        cyc();
        check("R2 off side", int'(offReq), g ? 2 : 1);
        check("R3 no early xfer", int'(xferReq), 0);
        cyc();
        check("R1 held flag no retrip", int'(offReq), 0);
        check("R3 xfer opposite", int'(xferReq), g ? 1 : 2);
        cyc();
        check("R3 xfer single", int'(xferReq), 0);
        check("R1 held flag still quiet", int'(offReq), 0);
        ocpPos = 1'b0; ocpNeg = 1'b0;
        cyc();
      end
    end
    gateHi = 1'b0;
    cyc();
    cleanPeriods();

    // R4: sweep each tick position of the persistence window
    tripLow();
    for (int n = 1; n <= P + 1; n++) begin
      tickOnce();
      check("R4 shutdown timing", int'(shutdown), (n == P + 1) ? 1 : 0);
    end

    // R6 R7 R8: sweep the shutdown interval with flag activity inside
    ocpPos = 1'b1;
    for (int m = 1; m <= S; m++) begin
      ocpNeg = 1'b1; cyc();
      check("R8 no off in shutdown", int'(offReq), 0);
      ocpNeg = 1'b0; cyc();
      check("R8 no xfer in shutdown", int'(xferReq), 0);
      tickOnce();
      check("R6 shutdown length", int'(shutdown), (m < S) ? 1 : 0);
      check("R7 soft start", int'(softStart), (m == S) ? 1 : 0);
    end
    cyc();
    check("R7 soft start single", int'(softStart), 0);
    check("R8 held flag after exit", int'(offReq), 0);
    cyc();
    check("R8 held flag stays quiet", int'(offReq), 0);
    ocpPos = 1'b0;
    cyc();

    // R5: clean periods clear the persistence count
    tripLow();
    for (int n = 0; n < P; n++) tickOnce();
    cleanPeriods();
    tripLow();
    for (int n = 0; n < P; n++) tickOnce();
    check("R5 count cleared", int'(shutdown), 0);
    tickOnce();
    check("R4 shutdown after fresh window", int'(shutdown), 1);
    finishShutdown();

    // R5: a trip in each period keeps the count running
    tripLow();
    tickOnce(); tickOnce();
    gateHi = 1'b1; cyc();
    gateHi = 1'b0; cyc();
    tripLow();
    gateHi = 1'b1; cyc();
    gateHi = 1'b0; cyc();
    for (int n = 0; n < P - 2; n++) tickOnce();
    check("R5 kept count not yet", int'(shutdown), 0);
    tickOnce();
    check("R5 kept count shutdown", int'(shutdown), 1);
    finishShutdown();

    // R10: transfer suppressed when shutdown is entered
    tripLow();
    for (int n = 0; n < P; n++) tickOnce();
    ocpNeg = 1'b1; cyc();
    check("R10 off before shutdown", int'(offReq), 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    check("R10 shutdown entered", int'(shutdown), 1);
    check("R10 xfer suppressed", int'(xferReq), 0);
    ocpNeg = 1'b0;
    finishShutdown();
    check("R6 final exit", int'(shutdown), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule